// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one byte at a time over a clocked serial link and acts as the clock master. A write to its data register starts a transfer. The block then drives eight transfer-clock cycles on `sclk`. It shifts the byte out on `txd` and, in the same eight cycles, shifts a byte in from `rxd`. The transfer clock comes from a prescaler. The prescaler divides the system clock by one of four divisors, and each divided tick is half a transfer-clock period.

A configuration register sets up the link:
- the divisor;
- the clock polarity, which also sets the level the clock rests at between transfers;
- the bit order;
- the handshake.

One shared handshake pin serves as a clear-to-send input or as a ready-to-receive output. The register picks the role, and handshaking can be switched off. A read-only bit reports when the transmit side holds no data. A one-cycle interrupt pulse marks each received byte, or, in error mode, only an overrun.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the configuration register reads 8'h80. Bits [6:0] are zero and bit 7, the transmit-empty flag, is 1. `sclk` and `txd` are high, `rxIrq` is low and `hsOe` is low.
- R2: The rate field, bits [1:0], selects the divisor: 00 gives 2, 01 gives 16, 10 gives 64 and 11 gives 512 system clocks. That many clocks separate each leading transfer-clock edge from the following trailing edge.
- R3: With polarity bit 2 at 0, `sclk` rests high. Data is driven on the falling edge and sampled on the rising edge.
- R4: With polarity bit 2 at 1, `sclk` rests low. Data is driven on the rising edge and sampled on the falling edge.
- R5: Order bit 3 selects the bit order for both shifting out and shifting in: 0 sends and assembles LSB first, 1 sends and assembles MSB first.
- R6: Transmit-empty (bit 7) reads 0 from the cycle after a data-register write (address 1) until the byte has been fully shifted. It then reads 1.
- R7: The received byte is read at address 1. Reading it with `rdEn` high frees the receive buffer. With irq-mode bit 6 at 0, `rxIrq` pulses once for every received byte.
- R8: With bit 6 at 1, a byte that arrives while the buffer is free raises no interrupt. A byte that completes while the previous byte is still unread is an overrun: it raises one `rxIrq` pulse and overwrites the buffer.
- R9: With role bit 4 at 0 and handshake-off bit 5 at 0, a pending transfer waits while `hsIn` is high and starts once it goes low. A transfer that has started completes even if `hsIn` rises.
- R10: With bit 5 at 1, `hsIn` is ignored, and `hsOe` is low.
- R11: With bit 4 at 1 and bit 5 at 0, `hsOe` is high. `hsOut` is low while the receive buffer is free and high while an unread byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | Write address: 0 configuration, 1 transmit data |
| regWdata | input | 8 | Write data |
| rdEn | input | 1 | Read strobe; a read of address 1 frees the receive buffer |
| rdSel | input | 1 | Read address: 0 configuration/status, 1 received data |
| rdData | output | 8 | Read data |
| sclk | output | 1 | Transfer clock |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| hsIn | input | 1 | Handshake pin input (clear to send) |
| hsOut | output | 1 | Handshake pin output (receiver busy when high) |
| hsOe | output | 1 | Handshake pin output enable |
| rxIrq | output | 1 | Receive interrupt pulse |

## Verification
The bench builds the block with its default divisors 2, 16, 64 and 512. With the smallest divisor, most transfers finish in a few dozen cycles, which leaves room to cover every combination of polarity and bit order, the overrun case and the handshake cases. The largest divisor still finishes a byte in about 8200 cycles, so the bench measures the spacing of the transfer-clock edges for all four rate codes.

// File: rtl/sxcvr_pkg.sv
package sxcvr_pkg;

  // Configuration register bits [6:0], MSB first
  typedef struct packed {
    logic       irqOnErr;
    logic       hsOff;
    logic       hsRole;
    logic       msbFirst;
    logic       clkPol;
    logic [1:0] rateSel;
  } cfg_t;

  typedef struct packed {
    logic loadTx;
    logic startShift;
    logic leadEdge;
    logic trailEdge;
    logic finish;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } state_t;

endpackage

// File: rtl/sxcvr_ctrl.sv
module sxcvr_ctrl
  import sxcvr_pkg::*;
#(
  parameter int DIV0 = 2,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64,
  parameter int DIV3 = 512,
  parameter int BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic       regSel,
  input  logic [6:0] cfgWdata,
  input  logic       rdEn,
  input  logic       rdSel,
  input  logic       hsIn,
  output cfg_t       cfg,
  output strobe_t    stb,
  output logic       phase,
  output logic       txEmpty,
  output logic       rxIrq,
  output logic       hsOut,
  output logic       hsOe
);

  localparam int CW = $clog2(DIV3);
  localparam int BW = $clog2(BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

  state_t        state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] divLast;
  logic [BW-1:0] bitCnt;
  logic          txFull;
  logic          rxFull;
  logic          ctsOk;
  logic          tick;
  logic          rxRead;
  logic          overrun;

  always_comb begin
    case (cfg.rateSel)
      2'd0:    divLast = CW'(DIV0 - 1);
      2'd1:    divLast = CW'(DIV1 - 1);
      2'd2:    divLast = CW'(DIV2 - 1);
      default: divLast = CW'(DIV3 - 1);
    endcase
  end

  assign ctsOk   = cfg.hsOff || cfg.hsRole || !hsIn;
  assign tick    = (state == ST_SHIFT) && (cnt == divLast);
  assign rxRead  = rdEn && rdSel;
  assign overrun = rxFull && !rxRead;

  assign stb.loadTx     = regWe && regSel;
  assign stb.startShift = (state == ST_IDLE) && txFull && ctsOk;
  assign stb.leadEdge   = tick && !phase;
  assign stb.trailEdge  = tick && phase;
  assign stb.finish     = (state == ST_DONE);

  assign txEmpty = !txFull && (state == ST_IDLE);
  assign hsOe    = cfg.hsRole && !cfg.hsOff;
  assign hsOut   = hsOe && rxFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      state  <= ST_IDLE;
      cnt    <= '0;
      phase  <= 1'b0;
      bitCnt <= '0;
      txFull <= 1'b0;
      rxFull <= 1'b0;
      rxIrq  <= 1'b0;
    end else begin
      rxIrq <= 1'b0;
      if (regWe && !regSel) cfg <= cfg_t'(cfgWdata);
      if (stb.loadTx) txFull <= 1'b1;
      else if (stb.startShift) txFull <= 1'b0;
      if (rxRead) rxFull <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (stb.startShift) begin
            state  <= ST_SHIFT;
            cnt    <= '0;
            phase  <= 1'b0;
            bitCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            cnt   <= '0;
            phase <= ~phase;
            if (phase) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) state <= ST_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state  <= ST_IDLE;
          rxFull <= 1'b1;
          rxIrq  <= cfg.irqOnErr ? overrun : 1'b1;
        end
      endcase
    end
  end

  // R6
  tx_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.startShift |=> !txEmpty);

  // R2
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.leadEdge |=> !stb.trailEdge);

  // R9
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !cfg.hsOff && !cfg.hsRole && hsIn && !(regWe && !regSel))
      |=> state == ST_IDLE);

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> $past(state == ST_DONE));

  // R11
  rts_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsOe && $past(state == ST_DONE)) |-> hsOut);

endmodule

// File: rtl/sxcvr_datapath.sv
module sxcvr_datapath
  import sxcvr_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  cfg_t            cfg,
  input  strobe_t         stb,
  input  logic            phase,
  input  logic [BITS-1:0] wdata,
  input  logic            rxd,
  output logic            sclk,
  output logic            txd,
  output logic [BITS-1:0] rxByte
);

  logic [BITS-1:0] txBuf;
  logic [BITS-1:0] txSh;
  logic [BITS-1:0] rxSh;

  assign sclk = ~cfg.clkPol ^ phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf  <= '0;
      txSh   <= '0;
      rxSh   <= '0;
      rxByte <= '0;
      txd    <= 1'b1;
    end else begin
      if (stb.loadTx) txBuf <= wdata;
      if (stb.startShift) txSh <= txBuf;
      if (stb.leadEdge) txd <= cfg.msbFirst ? txSh[BITS-1] : txSh[0];
      if (stb.trailEdge) begin
        if (cfg.msbFirst) begin
          txSh <= {txSh[BITS-2:0], 1'b0};
          rxSh <= {rxSh[BITS-2:0], rxd};
        end else begin
          txSh <= {1'b0, txSh[BITS-1:1]};
          rxSh <= {rxd, rxSh[BITS-1:1]};
        end
      end
      if (stb.finish) begin
        rxByte <= rxSh;
        txd    <= 1'b1;
      end
    end
  end

  // R3
  txd_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txd) |-> $past(stb.leadEdge || stb.finish));

  // R4
  rx_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxSh) |-> $past(stb.trailEdge));

  // R7
  rx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxByte) |-> $past(stb.finish));

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sxcvr_pkg::*;
#(
  parameter int DIV0 = 2,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64,
  parameter int DIV3 = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic       regSel,
  input  logic [7:0] regWdata,
  input  logic       rdEn,
  input  logic       rdSel,
  output logic [7:0] rdData,
  output logic       sclk,
  output logic       txd,
  input  logic       rxd,
  input  logic       hsIn,
  output logic       hsOut,
  output logic       hsOe,
  output logic       rxIrq
);

  cfg_t       cfg;
  strobe_t    stb;
  logic       phase;
  logic       txEmpty;
  logic [7:0] rxByte;

  sxcvr_ctrl #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .BITS(8)
  ) ctrlU (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .cfgWdata(regWdata[6:0]), .rdEn(rdEn), .rdSel(rdSel), .hsIn(hsIn),
    .cfg(cfg), .stb(stb), .phase(phase), .txEmpty(txEmpty),
    .rxIrq(rxIrq), .hsOut(hsOut), .hsOe(hsOe)
  );

  sxcvr_datapath #(.BITS(8)) dpU (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .phase(phase),
    .wdata(regWdata), .rxd(rxd), .sclk(sclk), .txd(txd), .rxByte(rxByte)
  );

  assign rdData = rdSel ? rxByte : {txEmpty, cfg};

endmodule

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0, regSel = 1'b0, rdEn = 1'b0, rdSel = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] rdData;
  logic       sclk, txd, hsOut, hsOe, rxIrq;
  logic       rxd = 1'b1;
  logic       hsIn = 1'b1;

  always #10 clk = ~clk;

  sync_serial_xcvr uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .sclk(sclk), .txd(txd),
    .rxd(rxd), .hsIn(hsIn), .hsOut(hsOut), .hsOe(hsOe), .rxIrq(rxIrq)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  // scoreboard state
  logic [7:0] txQ[$];
  logic [7:0] peerQ[$];
  string      txReq = "R3";
  logic       curPol = 1'b0, curMsb = 1'b0;
  int         bitIdx = 0, leadCnt = 0, irqCnt = 0;
  logic       seenLead = 1'b0, prevSclk = 1'b1;
  logic [7:0] txAsm = 8'h00, peerByte = 8'h00;
  longint     leadCyc = 0, lastGap = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / peer device
  always @(negedge clk) begin
    if (!rstN) begin
      prevSclk = sclk;
    end else begin
      if (sclk !== prevSclk) begin
        if (sclk != ~curPol) begin
          leadCnt++;
          seenLead = 1'b1;
          leadCyc = cyc;
          if (bitIdx == 0) peerByte = (peerQ.size() > 0) ? peerQ.pop_front() : 8'h00;
          rxd = curMsb ? peerByte[7-bitIdx] : peerByte[bitIdx];
        end else if (seenLead) begin
          seenLead = 1'b0;
          lastGap = cyc - leadCyc;
          txAsm[curMsb ? 7-bitIdx : bitIdx] = txd;
          bitIdx++;
          if (bitIdx == 8) begin
            bitIdx = 0;
            if (txQ.size() == 0) check({txReq, " unexpected byte"}, txAsm, 8'hxx);
            else check({txReq, " serial out"}, txAsm, txQ.pop_front());
          end
        end
      end
      prevSclk = sclk;
      if (rxIrq) irqCnt++;
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic strobe, output logic [7:0] d);
    @(negedge clk);
    rdSel = sel;
    #1 d = rdData;
    rdEn = strobe;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic logic [7:0] cfgb(input logic [1:0] rate, input logic pol, input logic msb,
                                      input logic role, input logic off, input logic errMode);
    return {1'b0, errMode, off, role, msb, pol, rate};
  endfunction

  task automatic setCfg(input logic [7:0] c);
    curPol = c[2];
    curMsb = c[3];
    wr(1'b0, c);
  endtask

  task automatic waitIdle(string req);
    logic [7:0] v;
    int n = 0;
    do begin
      rd(1'b0, 1'b0, v);
      n++;
    end while (!v[7] && n < 20000);
    check(req, v[7], 1'b1);
  endtask

  // driver: queue the expected serial byte and the peer's byte, start, wait
  task automatic xfer(string req, input logic [7:0] tx, input logic [7:0] peer);
    logic [7:0] v;
    txReq = req;
    txQ.push_back(tx);
    peerQ.push_back(peer);
    wr(1'b1, tx);
    rd(1'b0, 1'b0, v);
    check("R6 busy after write", v[7], 1'b0);
    waitIdle("R6 empty after shift");
    check({req, " all bytes seen"}, txQ.size(), 0);
  endtask

  task automatic readRx(string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(1'b1, 1'b1, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int i0, l0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, 1'b0, v);
    check("R1 cfg reset", v, 8'h80);
    check("R1 sclk idle", sclk, 1'b1);
    check("R1 txd idle", txd, 1'b1);
    check("R1 rxIrq", rxIrq, 1'b0);
    check("R1 hsOe", hsOe, 1'b0);

    // R3 polarity 0, LSB first; R10 hsIn high ignored
    setCfg(cfgb(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    hsIn = 1'b1;
    i0 = irqCnt;
    xfer("R3", 8'hA5, 8'h3C);
    check("R10 hsOe off", hsOe, 1'b0);
    check("R2 gap div2", 32'(lastGap), 2);
    check("R7 irq per byte", irqCnt - i0, 1);
    readRx("R7 rx byte", 8'h3C);

    // R5 MSB first, polarity 0
    setCfg(cfgb(2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
    xfer("R5", 8'h1E, 8'hC7);
    readRx("R5 rx msb", 8'hC7);

    // R4 polarity 1, LSB then MSB
    setCfg(cfgb(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    @(negedge clk);
    check("R4 sclk idle low", sclk, 1'b0);
    xfer("R4", 8'h6B, 8'h92);
    readRx("R4 rx lsb", 8'h92);
    setCfg(cfgb(2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
    xfer("R4", 8'h2D, 8'h58);
    readRx("R4 rx msb", 8'h58);
    check("R4 sclk idle after", sclk, 1'b0);

    // R2 remaining rates
    setCfg(cfgb(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    xfer("R2", 8'h11, 8'hEE);
    check("R2 gap div16", 32'(lastGap), 16);
    readRx("R2 rx", 8'hEE);
    setCfg(cfgb(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    xfer("R2", 8'h77, 8'h01);
    check("R2 gap div64", 32'(lastGap), 64);
    readRx("R2 rx", 8'h01);
    setCfg(cfgb(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    xfer("R2", 8'hF0, 8'h0F);
    check("R2 gap div512", 32'(lastGap), 512);
    readRx("R2 rx", 8'h0F);

    // R8 error-only interrupt and overrun
    setCfg(cfgb(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    i0 = irqCnt;
    xfer("R8", 8'h33, 8'hAA);
    check("R8 no irq normal", irqCnt - i0, 0);
    xfer("R8", 8'h44, 8'h55);
    check("R8 irq on overrun", irqCnt - i0, 1);
    readRx("R8 newest byte", 8'h55);

    // R9 clear-to-send gating
    setCfg(cfgb(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R9 hsOe low", hsOe, 1'b0);
    hsIn = 1'b1;
    l0 = leadCnt;
    txReq = "R9";
    txQ.push_back(8'hC3);
    peerQ.push_back(8'h3A);
    wr(1'b1, 8'hC3);
    repeat (100) @(negedge clk);
    check("R9 held no edges", leadCnt - l0, 0);
    rd(1'b0, 1'b0, v);
    check("R9 held not empty", v[7], 1'b0);
    hsIn = 1'b0;
    while (leadCnt - l0 < 3) @(negedge clk);
    hsIn = 1'b1;
    waitIdle("R9 completes after cts rises");
    check("R9 byte sent", txQ.size(), 0);
    readRx("R9 rx", 8'h3A);

    // R11 ready-to-receive output
    setCfg(cfgb(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    check("R11 hsOe", hsOe, 1'b1);
    check("R11 ready", hsOut, 1'b0);
    xfer("R11", 8'h5A, 8'h69);
    check("R11 busy pending", hsOut, 1'b1);
    readRx("R11 rx", 8'h69);
    @(negedge clk);
    check("R11 ready after read", hsOut, 1'b0);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule